// File: doc/BRIEF.md
# Block Erase Command Sequencer with Status Register

This block sits between a parallel host bus and a NOR-style flash array. It turns command bytes written on the bus into a block erase. It keeps an 8-bit status byte, and it decides whether a bus read returns array contents or that status byte. An erase is armed by a setup byte and launched by a confirm byte. The confirm byte must arrive on the very next write, and its address picks the block. The array is told which block to wipe through a level enable and a block number. The erase duration is modelled by an internal counter whose length is taken from an input.

A running erase can be paused so the host can read other blocks, and then continued. Failed sequences leave error flags in the status byte. These flags stay set until the host writes an explicit clear. Erasing the top (boot) block also needs a separate unlock input.

Top module: `erase_cmd_ctrl`

Status byte layout: bit 7 ready (1 = no erase running), bit 6 erase paused, bit 5 erase error, bit 4 write/sequence error, bit 3 programming-voltage error, bits 2:0 always 0. The block number is the upper BLK_W bits of the address; block 15 is the boot block. Command codes: FFh array read, 70h status read, 50h clear errors, 20h erase setup, D0h erase confirm and resume, B0h pause.

## Requirements
- R1: After reset the read path returns array data, eraseEn is 0 and the status byte is 80h.
- R2: FFh selects array reads and 70h selects status reads; in status-read mode every address returns the status byte.
- R3: 20h followed on the next write by D0h starts an erase: eraseEn goes to 1, eraseBlk holds the upper address bits of the D0h write, and status bit 7 reads 0.
- R4: An erase lasts eraseLen clock edges from the confirm edge, after which bit 7 is 1 and eraseEn is 0; reads keep returning status until a new command is written.
- R5: Any byte other than D0h after 20h starts no erase, sets bits 5 and 4, and selects status reads.
- R6: If vppOk is 0 at the confirm write, bits 3 and 5 are set and no erase starts; while bit 3 is set, a later 20h/D0h pair is refused and sets bit 5.
- R7: Bits 5:3 stay set through other commands and through a later successful erase; only 50h, written while no erase is in progress, clears them.
- R8: While an erase runs, only B0h has an effect; FFh, 50h and 20h change neither the read selection, the error bits nor the erase timing.
- R9: B0h takes effect one edge after it is accepted. From then on bits 6 and 7 read 1, eraseEn is 0, and the erase counter is frozen. D0h resumes with only the remaining time left.
- R10: While paused, only FFh, 70h and D0h are acted upon. In array-read mode, addresses outside the erasing block return array data and addresses inside it return status.
- R11: D0h written before the pause takes effect continues the erase with bit 6 never set and the total erase time unchanged.
- R12: An erase of block 15 is refused with bit 5 set unless bootUnlock is 1 at the confirm. If bootUnlock falls during that erase, the erase ends at the next edge with bit 5 set.
- R13: While an erase is running or waiting to pause, every read returns the status byte whatever the address or read mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Bus write strobe, one command per cycle |
| wrAddr | input | ADDR_W | Write address; upper BLK_W bits select the block |
| wrData | input | 8 | Command byte |
| rdAddr | input | ADDR_W | Read address |
| rdData | output | 8 | Read data: array contents or status byte |
| arrData | input | 8 | Array contents at rdAddr |
| vppOk | input | 1 | Programming voltage is valid |
| bootUnlock | input | 1 | Permits erasing the boot block |
| eraseLen | input | CNT_W | Erase duration in clock cycles (0 acts as 1) |
| eraseEn | output | 1 | Array erase enable, low while paused |
| eraseBlk | output | BLK_W | Block being erased |

## Verification
The assertions assume a write strobe of at most one command per edge, an eraseLen held steady while an erase is pending, and a reset applied before the first write. They also assume the pause flag can only appear while no erase edge is being counted. The directed scenarios drive eraseLen as a constant 10 and change vppOk and bootUnlock only on falling clock edges. Every command is issued as a single-cycle strobe at a falling edge, so each write lands on exactly one rising edge and the edge count to completion is known.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_ERASE,
    ST_SUSP_WAIT,
    ST_SUSPENDED
  } ctlState_t;

  // strobes and levels passed from control to datapath
  typedef struct packed {
    logic cntClr;
    logic cntEn;
    logic latchBlk;
    logic setVpp;
    logic setWr;
    logic setEr;
    logic clrErr;
    logic readStatus;
    logic busy;
    logic suspended;
  } ctlStrobes_t;

  localparam logic [7:0] CMD_READ_ARRAY  = 8'hFF;
  localparam logic [7:0] CMD_READ_STATUS = 8'h70;
  localparam logic [7:0] CMD_CLEAR       = 8'h50;
  localparam logic [7:0] CMD_SETUP       = 8'h20;
  localparam logic [7:0] CMD_CONFIRM     = 8'hD0;
  localparam logic [7:0] CMD_SUSPEND     = 8'hB0;
  localparam logic [7:0] CMD_RESUME      = 8'hD0;

endpackage

// File: rtl/erase_ctl.sv
module erase_ctl
  import flash_erase_pkg::*;
#(
  parameter int BLK_W    = 4,
  parameter int BOOT_BLK = 15
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [7:0]       wrData,
  input  logic [BLK_W-1:0] wrBlk,
  input  logic [BLK_W-1:0] curBlk,
  input  logic             vppOk,
  input  logic             bootUnlock,
  input  logic             cntDone,
  input  logic             vppLock,
  output ctlStrobes_t      stb
);

  localparam logic [BLK_W-1:0] BOOT_ID = BLK_W'(BOOT_BLK);

  ctlState_t state, stateNext;
  logic statusMode, statusModeNext;
  logic bootHit, bootRun, bootAbort;

  assign bootHit   = (wrBlk == BOOT_ID);
  assign bootRun   = (curBlk == BOOT_ID);
  assign bootAbort = bootRun && !bootUnlock;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      statusMode <= 1'b0;
    end else begin
      state      <= stateNext;
      statusMode <= statusModeNext;
    end
  end

  always_comb begin
    stateNext      = state;
    statusModeNext = statusMode;
    stb            = '0;
    case (state)
      ST_IDLE: begin
        if (wrEn) begin
          case (wrData)
            CMD_READ_ARRAY:  statusModeNext = 1'b0;
            CMD_READ_STATUS: statusModeNext = 1'b1;
            CMD_CLEAR:       stb.clrErr     = 1'b1;
            CMD_SETUP: begin
              stateNext      = ST_SETUP;
              statusModeNext = 1'b1;
            end
            default: ;
          endcase
        end
      end
      ST_SETUP: begin
        if (wrEn) begin
          statusModeNext = 1'b1;
          stateNext      = ST_IDLE;
          if (wrData == CMD_CONFIRM) begin
            if (vppLock) begin
              stb.setEr = 1'b1;
            end else if (!vppOk) begin
              stb.setVpp = 1'b1;
              stb.setEr  = 1'b1;
            end else if (bootHit && !bootUnlock) begin
              stb.setEr = 1'b1;
            end else begin
              stb.cntClr   = 1'b1;
              stb.latchBlk = 1'b1;
              stateNext    = ST_ERASE;
            end
          end else begin
            stb.setWr = 1'b1;
            stb.setEr = 1'b1;
          end
        end
      end
      ST_ERASE, ST_SUSP_WAIT: begin
        stb.cntEn = 1'b1;
        if (bootAbort) begin
          stb.setEr = 1'b1;
          stateNext = ST_IDLE;
        end else if (cntDone) begin
          stateNext = ST_IDLE;
        end else if (state == ST_ERASE) begin
          if (wrEn && wrData == CMD_SUSPEND) stateNext = ST_SUSP_WAIT;
        end else if (wrEn && wrData == CMD_RESUME) begin
          stateNext = ST_ERASE;
        end else begin
          stateNext = ST_SUSPENDED;
        end
      end
      ST_SUSPENDED: begin
        if (wrEn) begin
          case (wrData)
            CMD_READ_ARRAY:  statusModeNext = 1'b0;
            CMD_READ_STATUS: statusModeNext = 1'b1;
            CMD_RESUME: begin
              stateNext      = ST_ERASE;
              statusModeNext = 1'b1;
            end
            default: ;
          endcase
        end
      end
      default: stateNext = ST_IDLE;
    endcase
    stb.readStatus = statusMode;
    stb.busy       = (state == ST_ERASE) || (state == ST_SUSP_WAIT);
    stb.suspended  = (state == ST_SUSPENDED);
  end

endmodule

// File: rtl/erase_dp.sv
module erase_dp
  import flash_erase_pkg::*;
#(
  parameter int BLK_W = 4,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobes_t      stb,
  input  logic [BLK_W-1:0] wrBlk,
  input  logic [BLK_W-1:0] rdBlk,
  input  logic [CNT_W-1:0] eraseLen,
  input  logic [7:0]       arrData,
  output logic             cntDone,
  output logic             vppLock,
  output logic [BLK_W-1:0] curBlk,
  output logic [7:0]       statusByte,
  output logic [7:0]       rdData
);

  logic [CNT_W-1:0] cnt;
  logic [2:0]       errBits;   // {erase, write, vpp}
  logic [CNT_W:0]   cntPlusOne;
  logic             showStatus;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt     <= '0;
      curBlk  <= '0;
      errBits <= '0;
    end else begin
      if (stb.cntClr)      cnt <= '0;
      else if (stb.cntEn)  cnt <= cnt + 1'b1;
      if (stb.latchBlk)    curBlk <= wrBlk;
      if (stb.clrErr) begin
        errBits <= '0;
      end else begin
        if (stb.setEr)  errBits[2] <= 1'b1;
        if (stb.setWr)  errBits[1] <= 1'b1;
        if (stb.setVpp) errBits[0] <= 1'b1;
      end
    end
  end

  assign cntPlusOne = {1'b0, cnt} + 1'b1;
  assign cntDone    = stb.cntEn && (cntPlusOne >= {1'b0, eraseLen});
  assign vppLock    = errBits[0];
  assign statusByte = {!stb.busy, stb.suspended, errBits, 3'b000};

  assign showStatus = stb.readStatus || stb.busy ||
                      (stb.suspended && rdBlk == curBlk);
  assign rdData     = showStatus ? statusByte : arrData;

endmodule

// File: rtl/erase_cmd_ctrl.sv
module erase_cmd_ctrl
  import flash_erase_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int BLK_W    = 4,
  parameter int CNT_W    = 16,
  parameter int BOOT_BLK = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        rdData,
  input  logic [7:0]        arrData,
  input  logic              vppOk,
  input  logic              bootUnlock,
  input  logic [CNT_W-1:0]  eraseLen,
  output logic              eraseEn,
  output logic [BLK_W-1:0]  eraseBlk
);

  localparam int OFS_W = ADDR_W - BLK_W;

  ctlStrobes_t      stb;
  logic             cntDone, vppLock;
  logic [BLK_W-1:0] wrBlk, rdBlk, curBlk;
  logic [7:0]       statusByte;
  logic             unusedOffsets;

  assign wrBlk         = wrAddr[ADDR_W-1 -: BLK_W];
  assign rdBlk         = rdAddr[ADDR_W-1 -: BLK_W];
  assign unusedOffsets = ^{wrAddr[OFS_W-1:0], rdAddr[OFS_W-1:0]};

  erase_ctl #(.BLK_W(BLK_W), .BOOT_BLK(BOOT_BLK)) u_ctl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .wrBlk(wrBlk),
    .curBlk(curBlk), .vppOk(vppOk), .bootUnlock(bootUnlock),
    .cntDone(cntDone), .vppLock(vppLock), .stb(stb)
  );

  erase_dp #(.BLK_W(BLK_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrBlk(wrBlk), .rdBlk(rdBlk),
    .eraseLen(eraseLen), .arrData(arrData), .cntDone(cntDone),
    .vppLock(vppLock), .curBlk(curBlk), .statusByte(statusByte),
    .rdData(rdData)
  );

  assign eraseEn  = stb.busy;
  assign eraseBlk = curBlk;

endmodule

// File: rtl/erase_cmd_ctrl_chk.sv
module erase_cmd_ctrl_chk #(
  parameter int BLK_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic [7:0]       wrData,
  input logic             eraseEn,
  input logic [BLK_W-1:0] eraseBlk,
  input logic [7:0]       statusByte,
  input logic [7:0]       rdData
);

  // R3: an erase can only begin right after a D0h write
  p_start_on_confirm_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(eraseEn) |-> $past(wrEn && wrData == 8'hD0));

  // R3: the block under erase does not change mid-erase
  p_blk_stable_r3: assert property (@(posedge clk) disable iff (!rstN)
    (eraseEn && $past(eraseEn)) |-> $stable(eraseBlk));

  // R7: error bits never drop without a clear command
  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    !$past(wrEn && wrData == 8'h50) |->
      ((statusByte[5:3] & $past(statusByte[5:3])) == $past(statusByte[5:3])));

  // R9: paused means ready and array erase off
  p_pause_flags_r9: assert property (@(posedge clk) disable iff (!rstN)
    statusByte[6] |-> (statusByte[7] && !eraseEn));

  // R13: reads return status whenever not ready
  p_busy_reads_status_r13: assert property (@(posedge clk) disable iff (!rstN)
    !statusByte[7] |-> (rdData == statusByte));

  // R4: erase enable tracks not-ready
  p_enable_vs_ready_r4: assert property (@(posedge clk) disable iff (!rstN)
    eraseEn |-> !statusByte[7]);

endmodule

bind erase_cmd_ctrl erase_cmd_ctrl_chk #(.BLK_W(BLK_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .eraseEn(eraseEn),
  .eraseBlk(eraseBlk), .statusByte(statusByte), .rdData(rdData)
);

// File: tb/test_erase_cmd_ctrl.sv
`timescale 1ns/1ps
module test_erase_cmd_ctrl;

  localparam int ADDR_W = 12;
  localparam int BLK_W  = 4;
  localparam int CNT_W  = 16;
  localparam int LEN    = 10;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              wrEn = 1'b0;
  logic [ADDR_W-1:0] wrAddr = '0;
  logic [7:0]        wrData = '0;
  logic [ADDR_W-1:0] rdAddr = '0;
  logic [7:0]        rdData;
  logic [7:0]        arrData;
  logic              vppOk = 1'b1;
  logic              bootUnlock = 1'b0;
  logic [CNT_W-1:0]  eraseLen = CNT_W'(LEN);
  logic              eraseEn;
  logic [BLK_W-1:0]  eraseBlk;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  // array model: contents depend on address
  assign arrData = rdAddr[7:0] ^ 8'h5A;

  erase_cmd_ctrl i_erase_cmd_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .arrData(arrData), .vppOk(vppOk),
    .bootUnlock(bootUnlock), .eraseLen(eraseLen), .eraseEn(eraseEn),
    .eraseBlk(eraseBlk)
  );

  function automatic logic [7:0] arrOf(logic [ADDR_W-1:0] a);
    return a[7:0] ^ 8'h5A;
  endfunction

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic rdChk(string tag, logic [ADDR_W-1:0] a, logic [7:0] exp);
    rdAddr = a;
    #1;
    chk(tag, rdData, exp);
  endtask

  task automatic enChk(string tag, logic exp);
    chk(tag, {7'd0, eraseEn}, {7'd0, exp});
  endtask

  // caller is between edges; returns after the write edge
  task automatic wr(logic [ADDR_W-1:0] a, logic [7:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitCyc(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    rdChk("R1 array after reset", 12'h123, arrOf(12'h123));
    enChk("R1 eraseEn after reset", 1'b0);
    wr(12'h000, 8'h70);
    rdChk("R1 status after reset", 12'h123, 8'h80);
  endtask

  task automatic t_modes;
    wr(12'h000, 8'hFF);
    rdChk("R2 array mode", 12'h2A4, arrOf(12'h2A4));
    wr(12'h000, 8'h70);
    rdChk("R2 status mode addr a", 12'h2A4, 8'h80);
    rdChk("R2 status mode addr b", 12'hE01, 8'h80);
    wr(12'h000, 8'hFF);
  endtask

  task automatic t_basic;
    wr(12'h777, 8'h20);
    wr(12'h345, 8'hD0);
    enChk("R3 eraseEn on", 1'b1);
    chk("R3 eraseBlk", {4'd0, eraseBlk}, 8'h03);
    rdChk("R13 status while busy", 12'h7FF, 8'h00);
    wr(12'h000, 8'hFF);
    rdChk("R8 FF ignored busy", 12'h123, 8'h00);
    waitCyc(LEN - 3);
    rdChk("R4 still busy", 12'h123, 8'h00);
    waitCyc(1);
    rdChk("R4 busy last", 12'h123, 8'h00);
    waitCyc(1);
    rdChk("R4 ready", 12'h123, 8'h80);
    enChk("R4 eraseEn off", 1'b0);
    wr(12'h000, 8'hFF);
    rdChk("R4 array after new cmd", 12'h123, arrOf(12'h123));
  endtask

  task automatic t_badSecond;
    wr(12'h000, 8'h20);
    wr(12'h300, 8'h40);
    rdChk("R5 seq error status", 12'h123, 8'hB0);
    enChk("R5 no erase", 1'b0);
    wr(12'h000, 8'hFF);
    rdChk("R7 array still works", 12'h123, arrOf(12'h123));
    wr(12'h000, 8'h70);
    rdChk("R7 errors kept", 12'h123, 8'hB0);
    wr(12'h000, 8'h50);
    rdChk("R7 cleared", 12'h123, 8'h80);
  endtask

  task automatic t_vpp;
    vppOk = 1'b0;
    wr(12'h000, 8'h20);
    wr(12'h100, 8'hD0);
    rdChk("R6 vpp error", 12'h123, 8'hA8);
    enChk("R6 no erase vpp low", 1'b0);
    vppOk = 1'b1;
    wr(12'h000, 8'h20);
    wr(12'h100, 8'hD0);
    enChk("R6 locked refuse", 1'b0);
    rdChk("R6 locked status", 12'h123, 8'hA8);
    wr(12'h000, 8'h50);
    rdChk("R7 clear vpp", 12'h123, 8'h80);
    wr(12'h000, 8'h20);
    wr(12'h100, 8'hD0);
    enChk("R6 erase after clear", 1'b1);
    waitCyc(LEN);
    rdChk("R6 erase done", 12'h123, 8'h80);
  endtask

  task automatic t_ignored;
    wr(12'h000, 8'h20);
    wr(12'h000, 8'h33);
    wr(12'h000, 8'h20);
    wr(12'h200, 8'hD0);
    rdChk("R7 errs during erase", 12'h123, 8'h30);
    wr(12'h000, 8'h50);
    rdChk("R8 clear ignored busy", 12'h123, 8'h30);
    wr(12'h000, 8'h20);
    waitCyc(LEN - 3);
    rdChk("R8 timing unchanged busy", 12'h123, 8'h30);
    waitCyc(1);
    rdChk("R7 errs after good erase", 12'h123, 8'hB0);
    wr(12'h200, 8'hD0);
    enChk("R8 setup was ignored", 1'b0);
    wr(12'h000, 8'h50);
    rdChk("R7 clear idle", 12'h123, 8'h80);
  endtask

  task automatic t_suspend;
    wr(12'h000, 8'h20);
    wr(12'h5C0, 8'hD0);
    waitCyc(3);
    wr(12'h000, 8'hB0);
    rdChk("R9 pause pending", 12'h234, 8'h00);
    waitCyc(1);
    rdChk("R9 paused flags", 12'h234, 8'hC0);
    enChk("R9 eraseEn off paused", 1'b0);
    waitCyc(20);
    rdChk("R9 frozen", 12'h234, 8'hC0);
    wr(12'h000, 8'hFF);
    rdChk("R10 other block array", 12'h234, arrOf(12'h234));
    rdChk("R10 own block status", 12'h512, 8'hC0);
    wr(12'h000, 8'h20);
    rdChk("R10 setup ignored", 12'h234, arrOf(12'h234));
    wr(12'h000, 8'h70);
    rdChk("R10 status mode paused", 12'h234, 8'hC0);
    wr(12'h000, 8'hD0);
    rdChk("R9 resumed", 12'h234, 8'h00);
    enChk("R9 eraseEn resumed", 1'b1);
    waitCyc(LEN - 6);
    rdChk("R9 remaining busy", 12'h234, 8'h00);
    waitCyc(1);
    rdChk("R9 done after remainder", 12'h234, 8'h80);
  endtask

  task automatic t_early;
    wr(12'h000, 8'h20);
    wr(12'h600, 8'hD0);
    waitCyc(2);
    wr(12'h000, 8'hB0);
    wr(12'h000, 8'hD0);
    rdChk("R11 no pause flag", 12'h123, 8'h00);
    enChk("R11 still erasing", 1'b1);
    waitCyc(LEN - 5);
    rdChk("R11 last busy", 12'h123, 8'h00);
    waitCyc(1);
    rdChk("R11 done on time", 12'h123, 8'h80);
  endtask

  task automatic t_boot;
    bootUnlock = 1'b0;
    wr(12'h000, 8'h20);
    wr(12'hF00, 8'hD0);
    rdChk("R12 boot locked", 12'h123, 8'hA0);
    enChk("R12 no boot erase", 1'b0);
    wr(12'h000, 8'h50);
    bootUnlock = 1'b1;
    wr(12'h000, 8'h20);
    wr(12'hF10, 8'hD0);
    enChk("R12 boot erase on", 1'b1);
    chk("R12 boot blk", {4'd0, eraseBlk}, 8'h0F);
    waitCyc(2);
    bootUnlock = 1'b0;
    waitCyc(1);
    rdChk("R12 unlock drop aborts", 12'h123, 8'hA0);
    enChk("R12 abort eraseEn", 1'b0);
    wr(12'h000, 8'h50);
    bootUnlock = 1'b1;
    wr(12'h000, 8'h20);
    wr(12'hF10, 8'hD0);
    waitCyc(LEN);
    rdChk("R12 boot erase done", 12'h123, 8'h80);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_modes();
    t_basic();
    t_badSecond();
    t_vpp();
    t_ignored();
    t_suspend();
    t_early();
    t_boot();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule